// File: doc/BRIEF.md
# CSR Access Permission Checker

This block decides, in the same cycle, whether an instruction that touches a control/status register must be rejected as illegal. It sits beside the register file and looks only at the 12-bit register address, the hart's current privilege, whether the hart is halted in debug mode, the active register width, whether the instruction would really write, and whether the file implements that address at all.

Access rights come from the address itself. The top two bits mark a register as read-only when both are set. The next two bits give the lowest privilege that may touch it. Two address windows carry extra rules. A sixteen-entry block is reserved for the debugger. The upper-half counter aliases exist only for 32-bit harts.

The block has no state. The `csr_illegal` output and the decoded `csr_read_only` flag follow the inputs combinationally, so the trap logic can use them in the decode cycle.

Top module: `csr_perm_check`

## Requirements
- R1: `csr_read_only` is 1 exactly when address bits [11:10] are both 1, whatever the other inputs are.
- R2: Outside debug mode, an access is illegal when the privilege input (0 user, 1 supervisor, 3 machine, compared as an unsigned number) is below address bits [9:8].
- R3: An access with `wr_intent` set to an address whose bits [11:10] are 2'b11 is illegal.
- R4: An access without `wr_intent` to a read-only address is legal when no other rule applies. Example: machine mode, address 0xF11, implemented, 32-bit width.
- R5: Any access to 0x7B0–0x7BF outside debug mode is illegal, even in machine mode.
- R6: In machine mode, outside debug mode, reads and writes of an implemented address in 0x7A0–0x7AF are legal.
- R7: When `xlen64` is 1, any access to 0xC80–0xC9F or 0xB80–0xB9F is illegal.
- R8: When `xlen64` is 0, those two upper-half windows follow only the other rules.
- R9: An access with `addr_present` at 0 is illegal.
- R10: In debug mode the privilege check passes for every address, 0x7B0–0x7BF included, regardless of the privilege input.
- R11: The outputs depend only on the present inputs. They settle in the same cycle the inputs change, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_addr | input | 12 | Register address of the access |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| dbg_mode | input | 1 | Hart is halted in debug mode |
| xlen64 | input | 1 | 1 when the hart runs with 64-bit registers |
| wr_intent | input | 1 | The instruction would actually write the register |
| addr_present | input | 1 | The register file implements this address |
| csr_illegal | output | 1 | Raise an illegal-instruction exception |
| csr_read_only | output | 1 | Address decodes as read-only |

## Verification
The bench uses several kinds of input pattern, and each one tests something different:
- Random addresses crossed with every privilege, debug, width and write-intent combination exercise all the rules together. They show whether any single rule is lost or inverted.
- Directed accesses at both edges of each special window (0x79F/0x7A0, 0x7AF/0x7B0, 0x7BF/0x7C0, 0xB7F/0xB80, 0xB9F/0xBA0, 0xC7F/0xC80, 0xC9F/0xCA0) detect off-by-one range decoding.
- Accesses made in user and supervisor mode at the exact minimum privilege, and one level below it, separate a strict comparison from an inclusive one.
- Pairs of accesses that differ only in write intent, or only in debug mode, show that those two inputs act only through their own rules.

// File: rtl/csr_perm_check.sv
module csr_perm_check #(
  parameter int          AW        = 12,
  parameter logic [11:0] DBG_BASE  = 12'h7B0,
  parameter int          DBG_SPAN  = 4,
  parameter logic [11:0] HI_CNT_U  = 12'hC80,
  parameter logic [11:0] HI_CNT_M  = 12'hB80,
  parameter int          HI_SPAN   = 5,
  parameter int          PW        = 2
) (
  input  logic [AW-1:0] csr_addr,
  input  logic [PW-1:0] cur_priv,
  input  logic          dbg_mode,
  input  logic          xlen64,
  input  logic          wr_intent,
  input  logic          addr_present,
  output logic          csr_illegal,
  output logic          csr_read_only
);
  localparam logic [PW-1:0] PRIV_TOP = '1;
  localparam int NHI = 2;
  localparam logic [11:0] HI_BASES [NHI] = '{HI_CNT_U, HI_CNT_M};

  logic [PW-1:0] min_priv, eff_priv;
  logic          below_priv, ro_write, in_dbg_win, dbg_block, hi_block;
  logic [NHI-1:0] in_hi;

  assign csr_read_only = &csr_addr[AW-1:AW-2];
  assign min_priv      = csr_addr[AW-3:AW-4];
  assign eff_priv      = dbg_mode ? PRIV_TOP : cur_priv;
  assign below_priv    = eff_priv < min_priv;
  assign ro_write      = csr_read_only & wr_intent;

  assign in_dbg_win = csr_addr[AW-1:DBG_SPAN] == DBG_BASE[AW-1:DBG_SPAN];
  assign dbg_block  = in_dbg_win & ~dbg_mode;

  for (genvar g = 0; g < NHI; g++) begin : g_hi
    assign in_hi[g] = csr_addr[AW-1:HI_SPAN] == HI_BASES[g][AW-1:HI_SPAN];
  end
  assign hi_block = xlen64 & (|in_hi);

  assign csr_illegal = below_priv | ro_write | dbg_block | hi_block | ~addr_present;
endmodule

// File: rtl/csr_perm_check_sva.sv
module csr_perm_check_sva (
  input logic [11:0] csr_addr,
  input logic [1:0]  cur_priv,
  input logic        dbg_mode,
  input logic        xlen64,
  input logic        wr_intent,
  input logic        addr_present,
  input logic        csr_illegal,
  input logic        csr_read_only
);
  logic known, hi_win;
  assign known  = !$isunknown({csr_addr, cur_priv, dbg_mode, xlen64, wr_intent, addr_present});
  assign hi_win = (csr_addr >= 12'hC80 && csr_addr <= 12'hC9F) ||
                  (csr_addr >= 12'hB80 && csr_addr <= 12'hB9F);

  always_comb begin
    if (known) begin
      AST_RO_FLAG: assert (csr_read_only == (csr_addr >= 12'hC00)); // R1
      AST_LOW_PRIV: assert (dbg_mode || cur_priv >= csr_addr[9:8] || csr_illegal); // R2
      AST_RO_WRITE: assert (!(wr_intent && csr_read_only) || csr_illegal); // R3
      AST_DBG_WIN: assert (dbg_mode || csr_addr < 12'h7B0 || csr_addr > 12'h7BF || csr_illegal); // R5
      AST_HIGH_HALF: assert (!(xlen64 && hi_win) || csr_illegal); // R7
      AST_ABSENT: assert (addr_present || csr_illegal); // R9
      AST_DBG_OPEN: assert (!(dbg_mode && addr_present && !wr_intent && !(xlen64 && hi_win)) || !csr_illegal); // R10
    end
  end
endmodule

bind csr_perm_check csr_perm_check_sva u_sva (
  .csr_addr(csr_addr), .cur_priv(cur_priv), .dbg_mode(dbg_mode), .xlen64(xlen64),
  .wr_intent(wr_intent), .addr_present(addr_present),
  .csr_illegal(csr_illegal), .csr_read_only(csr_read_only)
);

// File: tb/csr_perm_check_bench.sv
module csr_perm_check_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic [11:0] csr_addr;
  logic [1:0]  cur_priv;
  logic dbg_mode, xlen64, wr_intent, addr_present;
  logic csr_illegal, csr_read_only;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_perm_check u_csr_perm_check (
    .csr_addr(csr_addr), .cur_priv(cur_priv), .dbg_mode(dbg_mode), .xlen64(xlen64),
    .wr_intent(wr_intent), .addr_present(addr_present),
    .csr_illegal(csr_illegal), .csr_read_only(csr_read_only)
  );

  function automatic bit exp_ro(input logic [11:0] a);
    return a >= 12'hC00;
  endfunction

  function automatic bit exp_ill(input logic [11:0] a, input logic [1:0] p,
                                 input bit d, input bit x, input bit w, input bit pr);
    int need, have;
    bit bad = 0;
    need = (a >> 8) & 3;
    have = d ? 3 : p;
    if (have < need) bad = 1;
    if (w && a >= 12'hC00) bad = 1;
    if (!d && a >= 12'h7B0 && a <= 12'h7BF) bad = 1;
    if (x && ((a >= 12'hC80 && a <= 12'hC9F) || (a >= 12'hB80 && a <= 12'hB9F))) bad = 1;
    if (!pr) bad = 1;
    return bad;
  endfunction

  task automatic apply(input logic [11:0] a, input logic [1:0] p, input bit d,
                       input bit x, input bit w, input bit pr, input string tag);
    bit ei, er;
    @(negedge clk);
    csr_addr = a; cur_priv = p; dbg_mode = d; xlen64 = x; wr_intent = w; addr_present = pr;
    #1;
    ei = exp_ill(a, p, d, x, w, pr);
    er = exp_ro(a);
    n_cmp++;
    if (csr_illegal !== ei || csr_read_only !== er) begin
      n_bad++;
      $display("FAIL %s addr=%h priv=%0d dbg=%0d x64=%0d wr=%0d pr=%0d: ill=%b ro=%b expected ill=%b ro=%b",
               tag, a, p, d, x, w, pr, csr_illegal, csr_read_only, ei, er);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] pv [3] = '{2'd0, 2'd1, 2'd3};
    void'($urandom(32'h5EED_0042));
    // idle state: all-zero address, not implemented -> illegal (R9)
    apply(12'h000, 2'd3, 0, 0, 0, 0, "R9 idle");
    // R1 read-only decode at boundary
    apply(12'hBFF, 2'd3, 0, 0, 0, 1, "R1 bfF");
    apply(12'hC00, 2'd3, 0, 0, 0, 1, "R1 c00");
    // R2 exact minimum vs one below
    apply(12'h100, 2'd1, 0, 0, 0, 1, "R2 S at S");
    apply(12'h100, 2'd0, 0, 0, 0, 1, "R2 U at S");
    apply(12'h300, 2'd1, 0, 0, 1, 1, "R2 S at M");
    apply(12'h001, 2'd0, 0, 0, 1, 1, "R2 U at U");
    // R3 / R4 read-only write vs read
    apply(12'hF11, 2'd3, 0, 0, 1, 1, "R3 ro write");
    apply(12'hF11, 2'd3, 0, 0, 0, 1, "R4 ro read");
    apply(12'hC00, 2'd0, 0, 0, 0, 1, "R4 user ro read");
    // R5 / R6 / R10 debug windows
    apply(12'h79F, 2'd3, 0, 0, 1, 1, "R6 below");
    apply(12'h7A0, 2'd3, 0, 0, 1, 1, "R6 lo");
    apply(12'h7AF, 2'd3, 0, 0, 0, 1, "R6 hi");
    apply(12'h7B0, 2'd3, 0, 0, 0, 1, "R5 lo");
    apply(12'h7BF, 2'd3, 0, 0, 1, 1, "R5 hi");
    apply(12'h7C0, 2'd3, 0, 0, 1, 1, "R5 after");
    apply(12'h7B0, 2'd0, 1, 0, 1, 1, "R10 dbg win");
    apply(12'h300, 2'd0, 1, 0, 1, 1, "R10 dbg M");
    // R7 / R8 upper-half windows
    foreach (pv[i]) begin
      apply(12'hC80, pv[i], 0, 1, 0, 1, "R7 c80");
      apply(12'hC9F, pv[i], 0, 1, 0, 1, "R7 c9f");
      apply(12'hC80, pv[i], 0, 0, 0, 1, "R8 c80");
    end
    apply(12'hC7F, 2'd0, 0, 1, 0, 1, "R7 c7f");
    apply(12'hCA0, 2'd0, 0, 1, 0, 1, "R7 ca0");
    apply(12'hB7F, 2'd3, 0, 1, 0, 1, "R7 b7f");
    apply(12'hB80, 2'd3, 0, 1, 0, 1, "R7 b80");
    apply(12'hB9F, 2'd3, 0, 1, 1, 1, "R7 b9f");
    apply(12'hBA0, 2'd3, 0, 1, 0, 1, "R7 ba0");
    apply(12'hB80, 2'd3, 0, 0, 1, 1, "R8 b80");
    apply(12'hB80, 2'd3, 1, 1, 0, 1, "R7 dbg");
    // R9
    apply(12'h7A0, 2'd3, 1, 0, 0, 0, "R9 absent dbg");
    // R11 and all rules: random mix, each input changed within one cycle
    for (int k = 0; k < 3000; k++) begin
      apply(12'($urandom), pv[$urandom % 3], 1'($urandom), 1'($urandom),
            1'($urandom), ($urandom % 8) != 0, "R11 random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule